// File: doc/BRIEF.md
# Four-Slot Register Rename Stage

This block sits between decode and dispatch in an out-of-order core. Each cycle it takes a group of up to four decoded instructions, each with one logical destination and two logical sources. It turns those logical register numbers into physical register tags. A speculative mapping table holds the latest physical tag for every logical register, plus a ready bit for every physical register. A first-in first-out free list supplies fresh physical tags.

Dependencies inside a group are resolved in the same cycle. A later slot that reads a register written by an earlier slot of the same group receives the earlier slot's fresh tag, and that source is marked not ready. A later slot that writes the same register as an earlier slot records the earlier slot's fresh tag as its previous mapping.

The renamed group is registered and appears one cycle later. A writeback port sets physical ready bits. A commit port returns, in program order, the previous tags of up to four retiring instructions to the free list. When the free list cannot cover every destination in the group, the stall output rises and the whole group is dropped.

Top module: `reg_rename_unit`

## Requirements
- R1: Every slot with in_valid set is renamed in a cycle where stall is low, so out_valid on the next cycle equals the in_valid of the previous cycle; slots without in_valid come out with out_valid low.
- R2: A renamed slot whose destination is nonzero gets out_dst_en high and a fresh out_new_tag. Tags are taken from the head of the free list in slot order (slot 0 first), so the tags of one group are distinct and nonzero.
- R3: A source tag equals the physical tag most recently allocated to that logical register, as seen by all earlier renamed groups.
- R4: Within one group, a source in slot j that names the destination of an earlier slot i < j takes the new tag of the latest such i and reads not ready. A destination in slot j that repeats the destination of an earlier slot takes that slot's new tag as out_old_tag; otherwise out_old_tag is the table mapping.
- R5: All renamed fields are registered: they appear on the outputs on the clock edge after the inputs are presented, and they are held until the next edge.
- R6: stall is a combinational output that is high exactly when the number of valid slots with a nonzero destination exceeds the free list occupancy. In that cycle no slot is renamed, no tag is taken and the table is unchanged. A group with no destination never stalls.
- R7: Each commit_valid slot returns its commit_old_tag to the tail of the free list, in slot order. Returned tags are handed out again after all tags that were already queued, and they are not available in the cycle they are returned.
- R8: A source reads ready when its physical tag has been written back, and also when wb_valid carries that tag in the same cycle as the rename. A newly allocated tag reads not ready until it is written back.
- R9: Logical register 0 is never renamed. As a source it yields tag 0 and ready 1. As a destination it yields out_dst_en low, tags 0, and it takes no free list entry.
- R10: After reset, logical register i maps to physical register i, and every physical register reads ready. The free list holds physical registers 32 to 63 in ascending order. out_valid and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 4 | Per-slot valid of the incoming group |
| in_dst | input | 4x5 | Logical destination per slot, 0 means none |
| in_src_a | input | 4x5 | First logical source per slot |
| in_src_b | input | 4x5 | Second logical source per slot |
| wb_valid | input | 2 | Writeback port valid bits |
| wb_tag | input | 2x6 | Physical tag written back per port |
| commit_valid | input | 4 | Per-slot commit valid, program order |
| commit_old_tag | input | 4x6 | Previous physical tag released per committing slot |
| stall | output | 1 | Group cannot be renamed this cycle |
| out_valid | output | 4 | Registered per-slot renamed valid |
| out_dst_en | output | 4 | Registered: slot allocated a destination |
| out_src_a_tag | output | 4x6 | Registered physical tag of first source |
| out_src_a_rdy | output | 4 | Registered ready bit of first source |
| out_src_b_tag | output | 4x6 | Registered physical tag of second source |
| out_src_b_rdy | output | 4 | Registered ready bit of second source |
| out_new_tag | output | 4x6 | Registered freshly allocated destination tag |
| out_old_tag | output | 4x6 | Registered previous mapping of the destination |

## Verification
The bench targets chains inside one group: the same register written by several slots and read by later ones. A design without the in-group bypass would hand out stale table tags and wrong previous tags. The bench drains the free list to exactly the edge where a group needs one register more than remains, and where it needs exactly what remains. A partial rename or an off-by-one compare shows up as lost or duplicated tags in the following groups. A writeback in the same cycle as a dependent rename catches a design that reads the ready bit only from the stored table. Random traffic with commits refilling the free list checks FIFO reuse order against a bench model of map, ready bits and free queue.

// File: rtl/rn_pkg.sv
package rn_pkg;
    // Default geometry of the rename stage.
    localparam int RN_LOGICAL  = 32;
    localparam int RN_PHYSICAL = 64;
    localparam int RN_SLOTS    = 4;
    localparam int RN_WB_PORTS = 2;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int PW    = 6,
    parameter int DEPTH = 32,
    parameter int SLOTS = 4,
    parameter int FIRST = 32,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NW-1:0]             pop_cnt,
    input  logic [SLOTS-1:0]          push_vld,
    input  logic [SLOTS-1:0][PW-1:0]  push_tag,
    output logic [SLOTS-1:0][PW-1:0]  head_tag,
    output logic [CW-1:0]             avail
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] slot;
        logic [IW-1:0]            head;
        logic [IW-1:0]            tail;
        logic [CW-1:0]            count;
    } fl_t;

    fl_t           cur_q, nxt_d;
    logic [NW-1:0] push_n_d;

    always_comb begin
        nxt_d    = cur_q;
        push_n_d = '0;
        for (int i = 0; i < SLOTS; i++) begin
            head_tag[i] = cur_q.slot[IW'(cur_q.head + IW'(i))];
        end
        // Returned tags are packed onto the tail in slot order.
        for (int i = 0; i < SLOTS; i++) begin
            if (push_vld[i]) begin
                nxt_d.slot[IW'(cur_q.tail + IW'(push_n_d))] = push_tag[i];
                push_n_d = push_n_d + 1'b1;
            end
        end
        nxt_d.tail  = IW'(cur_q.tail + IW'(push_n_d));
        nxt_d.head  = IW'(cur_q.head + IW'(pop_cnt));
        nxt_d.count = CW'(cur_q.count + CW'(push_n_d) - CW'(pop_cnt));
    end

    assign avail = cur_q.count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cur_q.slot[i] <= PW'(FIRST + i);
            end
            cur_q.head  <= '0;
            cur_q.tail  <= '0;
            cur_q.count <= CW'(DEPTH);
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R6: the rename side never takes more tags than are queued.
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_cnt) <= int'(cur_q.count));

    // R7: commits never return more tags than the queue can hold.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_q.count) + int'(push_n_d) <= DEPTH);
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NLOG  = 32,
    parameter int NPHYS = 64,
    parameter int SLOTS = 4,
    parameter int WBP   = 2,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS-1:0]              wr_en,
    input  logic [SLOTS-1:0][LW-1:0]      wr_lreg,
    input  logic [SLOTS-1:0][PW-1:0]      wr_ptag,
    input  logic [WBP-1:0]                wb_vld,
    input  logic [WBP-1:0][PW-1:0]        wb_ptag,
    output logic [NLOG-1:0][PW-1:0]       map_o,
    output logic [NPHYS-1:0]              rdy_o
);
    typedef struct packed {
        logic [NLOG-1:0][PW-1:0] map;
        logic [NPHYS-1:0]        rdy;
    } mt_t;

    mt_t              cur_q, nxt_d;
    logic [NPHYS-1:0] wb_hit_d;

    always_comb begin
        wb_hit_d = '0;
        for (int k = 0; k < WBP; k++) begin
            if (wb_vld[k]) wb_hit_d[wb_ptag[k]] = 1'b1;
        end
        nxt_d     = cur_q;
        nxt_d.rdy = cur_q.rdy | wb_hit_d;
        // Writes in slot order: the latest slot for a register wins.
        for (int i = 0; i < SLOTS; i++) begin
            if (wr_en[i]) begin
                nxt_d.map[wr_lreg[i]] = wr_ptag[i];
                nxt_d.rdy[wr_ptag[i]] = 1'b0;
            end
        end
    end

    assign map_o = cur_q.map;
    assign rdy_o = cur_q.rdy | wb_hit_d;   // same-cycle writeback forward

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOG; i++) begin
                cur_q.map[i] <= PW'(i);
            end
            cur_q.rdy <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    for (genvar k = 0; k < WBP; k++) begin : g_wb_chk
        // R8: a written-back tag reads ready on the next cycle.
        a_r8_wb_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
            wb_vld[k] |=> cur_q.rdy[$past(wb_ptag[k])]);
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_wr_chk
        // R9: logical register 0 is never remapped.
        a_r9_zero_not_written: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[i] |-> wr_lreg[i] != '0);
    end
endmodule

// File: rtl/rn_group_resolve.sv
module rn_group_resolve #(
    parameter int NLOG  = 32,
    parameter int NPHYS = 64,
    parameter int SLOTS = 4,
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int NW   = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0]              in_vld,
    input  logic [SLOTS-1:0][LW-1:0]      in_dst,
    input  logic [SLOTS-1:0][LW-1:0]      in_src_a,
    input  logic [SLOTS-1:0][LW-1:0]      in_src_b,
    input  logic [NLOG-1:0][PW-1:0]       map_i,
    input  logic [NPHYS-1:0]              rdy_i,
    input  logic [SLOTS-1:0][PW-1:0]      free_tag,
    input  logic [CW-1:0]                 avail,
    output logic                          stall,
    output logic [NW-1:0]                 pop_cnt,
    output logic [SLOTS-1:0]              ren_vld,
    output logic [SLOTS-1:0]              dst_en,
    output logic [SLOTS-1:0][PW-1:0]      a_tag,
    output logic [SLOTS-1:0]              a_rdy,
    output logic [SLOTS-1:0][PW-1:0]      b_tag,
    output logic [SLOTS-1:0]              b_rdy,
    output logic [SLOTS-1:0][PW-1:0]      new_tag,
    output logic [SLOTS-1:0][PW-1:0]      old_tag
);
    logic [NW-1:0]           need_d;
    logic [NW-1:0]           cnt_d;
    logic [NLOG-1:0][PW-1:0] tmp_map_d;
    logic [NLOG-1:0]         tmp_busy_d;

    always_comb begin
        need_d = '0;
        for (int i = 0; i < SLOTS; i++) begin
            dst_en[i] = in_vld[i] && (in_dst[i] != '0);
            if (dst_en[i]) need_d = need_d + 1'b1;
        end
        stall = int'(need_d) > int'(avail);

        // Walk the slots in order against a working copy of the table:
        // this is the intra-group dependency check.
        tmp_map_d  = map_i;
        tmp_busy_d = '0;
        cnt_d      = '0;
        for (int i = 0; i < SLOTS; i++) begin
            ren_vld[i] = in_vld[i] && !stall;
            a_tag[i]   = tmp_map_d[in_src_a[i]];
            a_rdy[i]   = !tmp_busy_d[in_src_a[i]] && rdy_i[a_tag[i]];
            b_tag[i]   = tmp_map_d[in_src_b[i]];
            b_rdy[i]   = !tmp_busy_d[in_src_b[i]] && rdy_i[b_tag[i]];
            old_tag[i] = '0;
            new_tag[i] = '0;
            if (dst_en[i]) begin
                old_tag[i]                = tmp_map_d[in_dst[i]];
                new_tag[i]                = free_tag[cnt_d];
                tmp_map_d[in_dst[i]]      = free_tag[cnt_d];
                tmp_busy_d[in_dst[i]]     = 1'b1;
                cnt_d                     = cnt_d + 1'b1;
            end
        end
        pop_cnt = stall ? '0 : cnt_d;
    end
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
    parameter int NLOG  = rn_pkg::RN_LOGICAL,
    parameter int NPHYS = rn_pkg::RN_PHYSICAL,
    parameter int SLOTS = rn_pkg::RN_SLOTS,
    parameter int WBP   = rn_pkg::RN_WB_PORTS,
    localparam int LW   = $clog2(NLOG),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SLOTS-1:0]          in_valid,
    input  logic [SLOTS-1:0][LW-1:0]  in_dst,
    input  logic [SLOTS-1:0][LW-1:0]  in_src_a,
    input  logic [SLOTS-1:0][LW-1:0]  in_src_b,
    input  logic [WBP-1:0]            wb_valid,
    input  logic [WBP-1:0][PW-1:0]    wb_tag,
    input  logic [SLOTS-1:0]          commit_valid,
    input  logic [SLOTS-1:0][PW-1:0]  commit_old_tag,
    output logic                      stall,
    output logic [SLOTS-1:0]          out_valid,
    output logic [SLOTS-1:0]          out_dst_en,
    output logic [SLOTS-1:0][PW-1:0]  out_src_a_tag,
    output logic [SLOTS-1:0]          out_src_a_rdy,
    output logic [SLOTS-1:0][PW-1:0]  out_src_b_tag,
    output logic [SLOTS-1:0]          out_src_b_rdy,
    output logic [SLOTS-1:0][PW-1:0]  out_new_tag,
    output logic [SLOTS-1:0][PW-1:0]  out_old_tag
);
    localparam int DEPTH = NPHYS - NLOG;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NW    = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [SLOTS-1:0]          vld;
        logic [SLOTS-1:0]          den;
        logic [SLOTS-1:0][PW-1:0]  at;
        logic [SLOTS-1:0]          ar;
        logic [SLOTS-1:0][PW-1:0]  bt;
        logic [SLOTS-1:0]          br;
        logic [SLOTS-1:0][PW-1:0]  nt;
        logic [SLOTS-1:0][PW-1:0]  ot;
    } grp_t;

    grp_t                     out_q, out_d;
    logic [SLOTS-1:0][PW-1:0] free_tag;
    logic [CW-1:0]            avail;
    logic [NW-1:0]            pop_cnt;
    logic [NLOG-1:0][PW-1:0]  map_cur;
    logic [NPHYS-1:0]         rdy_cur;
    logic [SLOTS-1:0]         ren_vld, dst_en, a_rdy, b_rdy, wr_en;
    logic [SLOTS-1:0][PW-1:0] a_tag, b_tag, new_tag, old_tag;

    rn_free_list #(.PW(PW), .DEPTH(DEPTH), .SLOTS(SLOTS), .FIRST(NLOG)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_cnt  (pop_cnt),
        .push_vld (commit_valid),
        .push_tag (commit_old_tag),
        .head_tag (free_tag),
        .avail    (avail)
    );

    rn_group_resolve #(.NLOG(NLOG), .NPHYS(NPHYS), .SLOTS(SLOTS), .DEPTH(DEPTH)) u_resolve (
        .in_vld   (in_valid),
        .in_dst   (in_dst),
        .in_src_a (in_src_a),
        .in_src_b (in_src_b),
        .map_i    (map_cur),
        .rdy_i    (rdy_cur),
        .free_tag (free_tag),
        .avail    (avail),
        .stall    (stall),
        .pop_cnt  (pop_cnt),
        .ren_vld  (ren_vld),
        .dst_en   (dst_en),
        .a_tag    (a_tag),
        .a_rdy    (a_rdy),
        .b_tag    (b_tag),
        .b_rdy    (b_rdy),
        .new_tag  (new_tag),
        .old_tag  (old_tag)
    );

    assign wr_en = dst_en & ren_vld;

    rn_map_table #(.NLOG(NLOG), .NPHYS(NPHYS), .SLOTS(SLOTS), .WBP(WBP)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_lreg  (in_dst),
        .wr_ptag  (new_tag),
        .wb_vld   (wb_valid),
        .wb_ptag  (wb_tag),
        .map_o    (map_cur),
        .rdy_o    (rdy_cur)
    );

    always_comb begin
        out_d = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (ren_vld[i]) begin
                out_d.vld[i] = 1'b1;
                out_d.den[i] = dst_en[i];
                out_d.at[i]  = a_tag[i];
                out_d.ar[i]  = a_rdy[i];
                out_d.bt[i]  = b_tag[i];
                out_d.br[i]  = b_rdy[i];
                out_d.nt[i]  = new_tag[i];
                out_d.ot[i]  = old_tag[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid     = out_q.vld;
    assign out_dst_en    = out_q.den;
    assign out_src_a_tag = out_q.at;
    assign out_src_a_rdy = out_q.ar;
    assign out_src_b_tag = out_q.bt;
    assign out_src_b_rdy = out_q.br;
    assign out_new_tag   = out_q.nt;
    assign out_old_tag   = out_q.ot;

    // R6: a stalled group leaves nothing on the output.
    a_r6_stall_drops_group: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> out_valid == '0);

    // R5: anything on the output was accepted one edge earlier.
    a_r5_registered_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> !$past(stall));

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot_chk
        // R9: a fresh tag is never physical 0 and never the tag it replaces.
        a_r9_new_tag_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
            out_dst_en[i] |-> (out_new_tag[i] != '0) && (out_new_tag[i] != out_old_tag[i]));
        for (genvar j = i + 1; j < SLOTS; j++) begin : g_pair
            // R2: tags handed out in one group are distinct.
            a_r2_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
                (out_dst_en[i] && out_dst_en[j]) |-> out_new_tag[i] != out_new_tag[j]);
        end
    end
endmodule

// File: tb/tb_reg_rename_unit.sv
module tb_reg_rename_unit;
    import rn_pkg::*;
    localparam int L   = RN_LOGICAL;
    localparam int P   = RN_PHYSICAL;
    localparam int S   = RN_SLOTS;
    localparam int WBP = RN_WB_PORTS;
    localparam int LW  = $clog2(L);
    localparam int PW  = $clog2(P);

    logic                  clk, rst_n;
    logic [S-1:0]          in_valid, commit_valid, stall;
    logic [S-1:0][LW-1:0]  in_dst, in_src_a, in_src_b;
    logic [WBP-1:0]        wb_valid;
    logic [WBP-1:0][PW-1:0] wb_tag;
    logic [S-1:0][PW-1:0]  commit_old_tag;
    logic [S-1:0]          out_valid, out_dst_en, out_src_a_rdy, out_src_b_rdy;
    logic [S-1:0][PW-1:0]  out_src_a_tag, out_src_b_tag, out_new_tag, out_old_tag;
    logic                  stall_o;

    reg_rename_unit #(.NLOG(L), .NPHYS(P), .SLOTS(S), .WBP(WBP)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .commit_valid(commit_valid), .commit_old_tag(commit_old_tag), .stall(stall_o),
        .out_valid(out_valid), .out_dst_en(out_dst_en), .out_src_a_tag(out_src_a_tag),
        .out_src_a_rdy(out_src_a_rdy), .out_src_b_tag(out_src_b_tag),
        .out_src_b_rdy(out_src_b_rdy), .out_new_tag(out_new_tag), .out_old_tag(out_old_tag)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;

    // Bench model: mapping, ready bits, free queue, pending commits, unwritten tags.
    int m_map[L];
    bit m_rdy[P];
    int m_free[$];
    int m_pend[$];
    int m_infl[$];

    int e_vld[S], e_den[S], e_at[S], e_ar[S], e_bt[S], e_br[S], e_nt[S], e_ot[S];
    int e_stall;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drop_infl(input int t);
        for (int k = m_infl.size() - 1; k >= 0; k--) begin
            if (m_infl[k] == t) m_infl.delete(k);
        end
    endtask

    // One cycle: drive at negedge, predict, check stall, then check outputs after the edge.
    task automatic step(input bit [S-1:0] v, input int d[S], input int a[S], input int b[S],
                        input int nwb, input int wt[WBP], input int ncm);
        int need;
        int freed[$];
        @(negedge clk);
        in_valid = v;
        for (int i = 0; i < S; i++) begin
            in_dst[i]   = LW'(d[i]);
            in_src_a[i] = LW'(a[i]);
            in_src_b[i] = LW'(b[i]);
        end
        wb_valid = '0;
        for (int k = 0; k < WBP; k++) begin
            wb_tag[k] = PW'(wt[k]);
            if (k < nwb) begin
                wb_valid[k] = 1'b1;
                m_rdy[wt[k]] = 1'b1;
            end
        end
        commit_valid = '0;
        for (int c = 0; c < S; c++) begin
            commit_old_tag[c] = '0;
            if (c < ncm && m_pend.size() > 0) begin
                int t;
                t = m_pend.pop_front();
                commit_valid[c] = 1'b1;
                commit_old_tag[c] = PW'(t);
                freed.push_back(t);
                drop_infl(t);
            end
        end
        need = 0;
        for (int i = 0; i < S; i++) if (v[i] && d[i] != 0) need++;
        e_stall = (need > m_free.size()) ? 1 : 0;
        for (int i = 0; i < S; i++) begin
            e_vld[i] = 0; e_den[i] = 0; e_at[i] = 0; e_ar[i] = 0;
            e_bt[i] = 0; e_br[i] = 0; e_nt[i] = 0; e_ot[i] = 0;
            if (v[i] && e_stall == 0) begin
                e_vld[i] = 1;
                e_at[i] = m_map[a[i]]; e_ar[i] = m_rdy[e_at[i]];
                e_bt[i] = m_map[b[i]]; e_br[i] = m_rdy[e_bt[i]];
                if (d[i] != 0) begin
                    e_den[i] = 1;
                    e_ot[i] = m_map[d[i]];
                    e_nt[i] = m_free.pop_front();
                    m_map[d[i]] = e_nt[i];
                    m_rdy[e_nt[i]] = 1'b0;
                    m_infl.push_back(e_nt[i]);
                    m_pend.push_back(e_ot[i]);
                end
            end
        end
        foreach (freed[k]) m_free.push_back(freed[k]);
        #1;
        chk("R6", "stall", int'(stall_o), e_stall);
        @(posedge clk);
        #1;
        for (int i = 0; i < S; i++) begin
            chk("R1/R5", $sformatf("out_valid[%0d]", i), int'(out_valid[i]), e_vld[i]);
            if (e_vld[i] != 0) begin
                chk("R2/R9", $sformatf("dst_en[%0d]", i), int'(out_dst_en[i]), e_den[i]);
                chk("R2/R7", $sformatf("new_tag[%0d]", i), int'(out_new_tag[i]), e_nt[i]);
                chk("R4", $sformatf("old_tag[%0d]", i), int'(out_old_tag[i]), e_ot[i]);
                chk("R3/R4", $sformatf("src_a_tag[%0d]", i), int'(out_src_a_tag[i]), e_at[i]);
                chk("R3/R4", $sformatf("src_b_tag[%0d]", i), int'(out_src_b_tag[i]), e_bt[i]);
                chk("R8", $sformatf("src_a_rdy[%0d]", i), int'(out_src_a_rdy[i]), e_ar[i]);
                chk("R8", $sformatf("src_b_rdy[%0d]", i), int'(out_src_b_rdy[i]), e_br[i]);
            end
        end
    endtask

    initial begin
        int d[S], a[S], b[S], wt[WBP];
        void'($urandom(32'd7741));
        rst_n = 1'b0;
        in_valid = '0; in_dst = '0; in_src_a = '0; in_src_b = '0;
        wb_valid = '0; wb_tag = '0; commit_valid = '0; commit_old_tag = '0;
        for (int i = 0; i < L; i++) m_map[i] = i;
        for (int i = 0; i < P; i++) m_rdy[i] = 1'b1;
        for (int i = L; i < P; i++) m_free.push_back(i);
        wt = '{0, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state at the ports
        chk("R10", "out_valid after reset", int'(out_valid), 0);
        chk("R10", "stall after reset", int'(stall_o), 0);

        // R10 / R4 / R9: chain through r5 in one group, r0 as source and destination
        d = '{5, 5, 7, 0}; a = '{1, 5, 5, 7}; b = '{2, 0, 5, 0};
        step(4'b1111, d, a, b, 0, wt, 0);
        chk("R10", "first fresh tag", int'(out_new_tag[0]), 32);
        chk("R4", "slot1 reads slot0 tag", int'(out_src_a_tag[1]), 32);
        chk("R4", "slot1 old tag is slot0 new", int'(out_old_tag[1]), 32);
        chk("R9", "r0 source tag", int'(out_src_b_tag[3]), 0);
        chk("R9", "r0 source ready", int'(out_src_b_rdy[3]), 1);
        chk("R9", "r0 destination no alloc", int'(out_dst_en[3]), 0);

        // R8: write back r5's current producer while a group reads r5
        wt = '{m_map[5], 0};
        drop_infl(m_map[5]);
        d = '{9, 0, 0, 0}; a = '{5, 0, 0, 0}; b = '{7, 0, 0, 0};
        step(4'b0001, d, a, b, 1, wt, 0);
        chk("R8", "same-cycle writeback forward", int'(out_src_a_rdy[0]), 1);
        chk("R8", "unwritten producer not ready", int'(out_src_b_rdy[0]), 0);

        // R6: drain the free list; exact fit passes, one short stalls
        wt = '{0, 0};
        d = '{3, 4, 6, 8}; a = '{1, 1, 1, 1}; b = '{2, 2, 2, 2};
        while (m_free.size() >= 4 + 3) step(4'b1111, d, a, b, 0, wt, 0);
        d = '{10, 11, 12, 13};
        while (m_free.size() > 3) step(4'b0001, d, a, b, 0, wt, 0);
        step(4'b1111, d, a, b, 0, wt, 0);               // needs 4, has 3: stall
        chk("R6", "short group dropped", int'(out_valid), 0);
        step(4'b0111, d, a, b, 0, wt, 0);               // needs 3, has 3
        d = '{0, 0, 0, 0};
        step(4'b1111, d, a, b, 0, wt, 0);               // no destinations, empty list
        chk("R6", "no-destination group passes on empty list", int'(out_valid), 15);
        d = '{14, 0, 0, 0};
        step(4'b0001, d, a, b, 0, wt, 2);               // returns 2, cannot use them yet
        chk("R7", "returned tags not usable same cycle", int'(out_valid), 0);
        step(4'b0001, d, a, b, 0, wt, 0);
        chk("R7", "returned tag reused", int'(out_valid[0]), 1);

        // Random traffic with commits and writebacks
        for (int n = 0; n < 3000; n++) begin
            bit [S-1:0] v;
            int nwb, ncm;
            v = S'($urandom);
            for (int i = 0; i < S; i++) begin
                d[i] = ($urandom % 4 == 0) ? 0 : int'($urandom % 12);
                a[i] = int'($urandom % 12);
                b[i] = int'($urandom % L);
            end
            nwb = 0;
            for (int k = 0; k < WBP; k++) begin
                wt[k] = 0;
                if (m_infl.size() > 0 && ($urandom % 2) == 1) begin
                    int idx;
                    idx = int'($urandom % m_infl.size());
                    wt[nwb] = m_infl[idx];
                    m_infl.delete(idx);
                    nwb++;
                end
            end
            ncm = int'($urandom % 5);
            if (ncm > m_pend.size()) ncm = m_pend.size();
            step(v, d, a, b, nwb, wt, ncm);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R1 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule